// File: doc/BRIEF.md
# Latched Interrupt Controller with Global Mask

This block gathers interrupt requests from up to 26 peripheral sources of a small I/O processor and presents one pending line to the CPU. Every request sets a sticky bit in a status register; the bit stays set until software clears it with an acknowledge write. A per-source enable register selects which latched requests may interrupt, and a single global mask can silence the pending line as a whole. Source 3 is the DMA-completion request and source 9 is the audio-unit request; the remaining sources are assigned by the surrounding chip.

Software reaches three registers over a 32-bit register bus with a 4-bit byte-lane strobe. The word offset is decoded from address bits [6:2]: 0x70 is status (writes acknowledge), 0x74 is enable, and 0x78 is global control. Reading global control is a claim operation: it returns whether interrupts were unmasked and then masks them, so a handler can enter a critical section with one load and restore the previous state later with one store.

Read data is registered and appears one cycle after the access. The pending output is derived from registered state, so it reflects an access or a request one cycle after the clock edge that captured it.

Top module: `intc_top`

## Requirements
- R1: A synchronous active-low reset clears the status and enable registers, leaves the controller unmasked and holds `cpu_irq` low.
- R2: A high `irq_req[i]` in any cycle sets status bit i on that clock edge; the bit stays set while no acknowledge clears it, and a further request on a set bit leaves the status unchanged.
- R3: A write to offset 0x70 computes status = status AND (wdata OR NOT lanemask), where lanemask has byte k all ones when `bus_be[k]` is 1; a request arriving in the same cycle as the acknowledge wins and leaves its bit set.
- R4: A write to offset 0x74 computes enable = (enable AND NOT lanemask) OR (wdata AND lanemask); bits 26 to 31 of status and enable always read as zero.
- R5: A read of offset 0x78 returns 1 in bit 0 if the controller was unmasked before the read and 0 if it was masked, and after that read the controller is masked.
- R6: A write to offset 0x78 with `bus_be[0]` high sets the mask to NOT wdata[0] (1 unmasks, 0 masks); with `bus_be[0]` low it has no effect.
- R7: `cpu_irq` is high exactly when the controller is unmasked and (status AND enable) is nonzero, evaluated on the state after each clock edge.
- R8: Read data appears on `bus_rdata` in the cycle after the read access, ANDed with lanemask, and holds until the next read.
- R9: Offsets other than 0x70, 0x74 and 0x78 read as zero and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 26 | Request lines, one per source (bit 3 DMA, bit 9 audio) |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address; bits [6:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane strobe, bit k covers data bits 8k+7..8k |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Interrupt pending to the CPU |

## Verification
Every result of this block is due exactly one clock edge after its stimulus: status, enable and mask change on the edge that captures the access or request, `cpu_irq` follows combinationally from those registers, and `bus_rdata` is loaded on the edge of the read. The bench therefore drives each access or request on a falling edge, removes it on the next falling edge, and samples both `bus_rdata` and `cpu_irq` at that second falling edge, half a period after the edge that updated them. The claim read is checked twice in a row so the returned value before and after the side effect is distinguished, and the pending line is compared against the bench model after every register access of the sweeps.

// File: rtl/intc_pkg.sv
// Package: shared constants and helpers for the latched interrupt controller.
// Assumes a 32-bit register bus with four byte lanes.
package intc_pkg;

    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;

    // Register selectors, taken from address bits [6:2]
    localparam logic [4:0] SEL_STATUS = 5'h1C;   // byte offset 0x70
    localparam logic [4:0] SEL_ENABLE = 5'h1D;   // byte offset 0x74
    localparam logic [4:0] SEL_GCTL   = 5'h1E;   // byte offset 0x78

    // Fixed source assignments
    localparam int SRC_DMA_DONE = 3;
    localparam int SRC_AUDIO    = 9;

    // Expand a byte-lane strobe into a bit mask
    function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int k = 0; k < LANES; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/intc_status.sv
// Module: sticky status register.
// Each request bit sets its status bit; an acknowledge write keeps only the
// bits whose keep flag is 1. A request in the same cycle as an acknowledge
// wins. Assumes the keep vector is already lane-qualified by the caller.
module intc_status #(
    parameter int NUM_SRC = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               ack_we,
    input  logic [NUM_SRC-1:0] ack_keep,
    output logic [NUM_SRC-1:0] status
);

    logic [NUM_SRC-1:0] kept;

    // Bits surviving an acknowledge this cycle
    always_comb begin
        kept = ack_we ? (status & ack_keep) : status;
    end

    // Latch requests on top of the surviving bits
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= kept | req;
    end

    // R2: without an acknowledge no set bit ever clears
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_we |=> ((status & $past(status)) == $past(status)));

    // R2: every requested bit is set after the edge
    a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(req)) == $past(req)));

    // R3: an acknowledge never sets a bit that was neither set nor requested
    a_r3_ack_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((status & ~($past(status) | $past(req))) == '0));

endmodule

// File: rtl/intc_enable.sv
// Module: per-source enable register with lane-masked update.
// Bits outside the write mask keep their value. Assumes the mask is already
// expanded from the byte-lane strobe.
module intc_enable #(
    parameter int NUM_SRC = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] wmask,
    output logic [NUM_SRC-1:0] en
);

    // Merge new data into the selected bits only
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= '0;
        else if (we) en <= (en & ~wmask) | (wdata & wmask);
    end

    // R4: bits outside the mask are untouched by a write
    a_r4_outside_mask: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((en & ~$past(wmask)) == ($past(en) & ~$past(wmask))));

    // R4: without a write the register holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en));

endmodule

// File: rtl/intc_gmask.sv
// Module: global mask flag with claim-on-read.
// A read of the control register masks; a write sets mask = NOT bit 0.
// Assumes read and write hits are never high together.
module intc_gmask (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wbit,
    output logic masked
);

    // Update the mask from control accesses
    always_ff @(posedge clk) begin
        if (!rst_n)      masked <= 1'b0;
        else if (rd_hit) masked <= 1'b1;
        else if (wr_hit) masked <= ~wbit;
    end

    // R5: a control read always leaves the controller masked
    a_r5_claim: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> masked);

    // R6: the mask moves only on a control access
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit && !wr_hit) |=> $stable(masked));

endmodule

// File: rtl/intc_top.sv
// Module: latched interrupt controller top.
// Decodes the register bus, feeds the status, enable and mask blocks,
// returns registered lane-masked read data and drives the CPU pending line.
// Assumes one access per cycle and NUM_SRC no larger than the data width.
module intc_top #(
    parameter int NUM_SRC = 26,
    parameter int ADDR_W  = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          irq_req,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [intc_pkg::DATA_W-1:0] bus_wdata,
    input  logic [intc_pkg::LANES-1:0]  bus_be,
    output logic [intc_pkg::DATA_W-1:0] bus_rdata,
    output logic                        cpu_irq
);
    import intc_pkg::*;

    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [4:0]         reg_sel;
    logic               hit_status, hit_enable, hit_gctl, hit_any;
    logic               rd_acc, wr_acc;
    logic [DATA_W-1:0]  lane_mask;
    logic [NUM_SRC-1:0] status, en;
    logic               masked;
    logic [DATA_W-1:0]  rd_word;

    // Register selection from address bits [6:2]
    always_comb begin
        reg_sel    = bus_addr[6:2];
        hit_status = (reg_sel == SEL_STATUS);
        hit_enable = (reg_sel == SEL_ENABLE);
        hit_gctl   = (reg_sel == SEL_GCTL);
        hit_any    = hit_status | hit_enable | hit_gctl;
        rd_acc     = bus_sel & ~bus_wr;
        wr_acc     = bus_sel & bus_wr;
        lane_mask  = lane_bits(bus_be);
    end

    intc_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .ack_we   (wr_acc & hit_status),
        .ack_keep (bus_wdata[NUM_SRC-1:0] | ~lane_mask[NUM_SRC-1:0]),
        .status   (status)
    );

    intc_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_acc & hit_enable),
        .wdata (bus_wdata[NUM_SRC-1:0]),
        .wmask (lane_mask[NUM_SRC-1:0]),
        .en    (en)
    );

    intc_gmask u_gmask (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_acc & hit_gctl),
        .wr_hit (wr_acc & hit_gctl & bus_be[0]),
        .wbit   (bus_wdata[0]),
        .masked (masked)
    );

    // Select the word a read returns, before lane masking
    always_comb begin
        rd_word = '0;
        if (hit_status)      rd_word = {{PAD_W{1'b0}}, status};
        else if (hit_enable) rd_word = {{PAD_W{1'b0}}, en};
        else if (hit_gctl)   rd_word = {{(DATA_W-1){1'b0}}, ~masked};
    end

    // Register read data, qualified by the byte lanes
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_acc) bus_rdata <= rd_word & lane_mask;
    end

    // Pending line to the CPU
    always_comb begin
        cpu_irq = ~masked & (|(status & en));
    end

    // R7: a masked controller never signals the CPU
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        masked |-> !cpu_irq);

    // R9: an unmapped read returns zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && !hit_any) |=> (bus_rdata == '0));

    // R8: read data holds between reads
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(bus_rdata));

endmodule

// File: tb/sim_intc_top.sv
// Bench: sweeps sources, lane strobes and control sequences against a model.
module sim_intc_top;

    localparam int N = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [N-1:0] m_st, m_en;
    logic         m_mask;

    intc_top #(.NUM_SRC(N), .ADDR_W(7)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] lm(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag);
        chk(tag, {31'b0, cpu_irq}, {31'b0, (!m_mask && |(m_st & m_en))});
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [N-1:0] rq);
        logic [31:0] m;
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be; irq_req = rq;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; irq_req = '0;
        m = lm(be);
        if (a[6:2] == 5'h1C) m_st = m_st & (d[N-1:0] | ~m[N-1:0]);
        if (a[6:2] == 5'h1D) m_en = (m_en & ~m[N-1:0]) | (d[N-1:0] & m[N-1:0]);
        if (a[6:2] == 5'h1E && be[0]) m_mask = ~d[0];
        m_st = m_st | rq;
    endtask

    task automatic rd(input logic [6:0] a, input logic [3:0] be, output logic [31:0] q);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_sel = 0;
        q = bus_rdata;
        if (a[6:2] == 5'h1E) m_mask = 1'b1;
    endtask

    task automatic pulse(input logic [N-1:0] rq);
        @(negedge clk);
        irq_req = rq;
        @(negedge clk);
        irq_req = '0;
        m_st = m_st | rq;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        logic [31:0] d;
        m_st = '0; m_en = '0; m_mask = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq after reset", {31'b0, cpu_irq}, 32'h0);
        rd(7'h70, 4'hF, q); chk("R1 status after reset", q, 32'h0);
        rd(7'h74, 4'hF, q); chk("R1 enable after reset", q, 32'h0);
        rd(7'h78, 4'hF, q); chk("R1 unmasked after reset", q, 32'h1);
        wr(7'h78, 32'h1, 4'h1, '0);

        // R2 R3 R7: per-source sweep, enable all, latch, ack
        wr(7'h74, 32'hFFFF_FFFF, 4'hF, '0);
        rd(7'h74, 4'hF, q); chk("R4 enable bits above 25 read zero", q, 32'h03FF_FFFF);
        for (int i = 0; i < N; i++) begin
            pulse(N'(1) << i);
            chk_irq("R7 pending after request");
            rd(7'h70, 4'hF, q); chk("R2 status bit latched", q, {6'b0, m_st});
            pulse(N'(1) << i);
            rd(7'h70, 4'hF, q); chk("R2 repeated request no change", q, {6'b0, m_st});
            wr(7'h70, ~(32'h1 << i), 4'hF, '0);
            chk_irq("R7 pending after ack");
            rd(7'h70, 4'hF, q); chk("R3 ack clears bit", q, 32'h0);
        end

        // R3: ack limited to active lanes, over every strobe
        for (int b = 0; b < 16; b++) begin
            pulse({N{1'b1}});
            wr(7'h70, 32'h0, 4'(b), '0);
            rd(7'h70, 4'hF, q); chk("R3 lane-limited ack", q, {6'b0, m_st});
            wr(7'h70, 32'h0, 4'hF, '0);
        end

        // R3: request beats a same-cycle ack (DMA source)
        pulse(N'(1) << 3);
        wr(7'h70, 32'h0, 4'hF, N'(1) << 3);
        rd(7'h70, 4'hF, q); chk("R3 request wins over ack", q, 32'h0000_0008);
        wr(7'h70, 32'h0, 4'hF, '0);

        // R4 R7: enable lane writes over every strobe, audio source pending
        pulse(N'(1) << 9);
        for (int b = 0; b < 16; b++) begin
            d = 32'hA5C3_3C5A ^ (32'h0101_0101 * b);
            wr(7'h74, d, 4'(b), '0);
            rd(7'h74, 4'hF, q); chk("R4 lane-masked enable", q, {6'b0, m_en});
            chk_irq("R7 pending tracks enable");
        end

        // R8: read data lane masking
        wr(7'h74, 32'h03FF_FFFF, 4'hF, '0);
        for (int b = 0; b < 16; b++) begin
            rd(7'h74, 4'(b), q); chk("R8 read lane mask", q, 32'h03FF_FFFF & lm(4'(b)));
        end

        // R5 R6 R7: claim read and restore
        chk_irq("R7 pending before claim");
        rd(7'h78, 4'hF, q); chk("R5 first claim returns unmasked", q, 32'h1);
        chk_irq("R7 quiet after claim");
        rd(7'h78, 4'hF, q); chk("R5 second claim returns masked", q, 32'h0);
        wr(7'h78, 32'h0, 4'hE, '0);
        chk_irq("R6 no lane0 write ignored");
        wr(7'h78, 32'h1, 4'h1, '0);
        chk_irq("R6 write 1 unmasks");
        wr(7'h78, 32'hFFFF_FFFE, 4'hF, '0);
        chk_irq("R6 write 0 masks");
        rd(7'h78, 4'hF, q); chk("R6 masked reads zero", q, 32'h0);
        wr(7'h78, 32'h1, 4'hF, '0);
        chk_irq("R7 pending restored");

        // R9: unmapped offsets
        for (int o = 0; o < 32; o++) begin
            if (o != 28 && o != 29 && o != 30) begin
                wr(7'(o * 4), 32'h0, 4'hF, '0);
                rd(7'(o * 4), 4'hF, q); chk("R9 unmapped reads zero", q, 32'h0);
            end
        end
        rd(7'h70, 4'hF, q); chk("R9 status untouched", q, {6'b0, m_st});
        rd(7'h74, 4'hF, q); chk("R9 enable untouched", q, {6'b0, m_en});
        chk_irq("R9 mask untouched");

        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_st = '0; m_en = '0; m_mask = 1'b0;
        chk("R1 irq low after reset", {31'b0, cpu_irq}, 32'h0);
        rd(7'h70, 4'hF, q); chk("R1 status cleared", q, 32'h0);
        rd(7'h74, 4'hF, q); chk("R1 enable cleared", q, 32'h0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule